// File: doc/BRIEF.md
# Reference-Aligned Frame Pulse Generator

This block produces a top-of-frame pulse from two cascaded counters clocked by the output clock. A pixel counter runs across a programmable line length, and a line counter runs across a programmable frame height. The pulse is high for the whole of the first line of every output frame. The pulse rate is therefore the clock frequency divided by the product of the two lengths. For example, 1728 pixels by 625 lines at 27 MHz gives 25 frames per second.

A reference tracker follows an incoming reference frame. A line counter steps on each H-rate feedback strobe and is re-phased to line 1 by a reference frame-start pulse. A ratio counter counts reference frames modulo the numerator of the reduced input/output frame-rate ratio, which yields points where reference and output frames meet. Software arms alignment by setting an enable bit and raising an init bit. At the next such point, at the programmed reference-line offset, both output counters restart at the top of frame. While the enable stays set, the block re-aligns at every later point. If the reference frame start stops arriving, every counter keeps running from its terminal counts.

Top module: `frame_align_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both output counters are at zero and `framePulse` is 1.
- R2: When free running, consecutive rising edges of `framePulse` are `cfgPixPerLine` × `cfgLinesPerFrame` clock cycles apart.
- R3: Each frame pulse stays high for exactly `cfgPixPerLine` clock cycles.
- R4: `cfgInvalid` is 1 when `cfgLineOffset` is 0 or greater than `cfgRefLines`, and 0 otherwise. An invalid offset is used as if it equalled `cfgRefLines`, which means alignment at the reference frame start.
- R5: The reference line counter resets to 1. It is forced to 1 by `refFrameStart`, rises by one on each `hStrobe`, and returns to 1 on the strobe that ends line `cfgRefLines`. Without `refFrameStart` it keeps wrapping by itself.
- R6: An alignment point is an `hStrobe` (without `refFrameStart`) that ends the reference line equal to the effective offset, in a reference frame whose ratio index is 0. The ratio index starts at 0 and advances on every reference-line wrap, modulo `cfgFrameRatio`. A ratio of 0 or 1 makes every reference frame qualify.
- R7: A 0-to-1 change of `initReq` sampled while `alignEn` is 1 arms the block. At the next alignment point both output counters restart, so `framePulse` is 1 in the cycle after the clock edge that samples the strobe.
- R8: While `alignEn` remains 1, the block re-aligns at every later alignment point without a new init edge.
- R9: Clearing `alignEn` disarms the block at the next edge, and later alignment points leave the counters running freely.
- R10: Holding `initReq` at 1 does not re-arm the block; only a new 0-to-1 change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock driving all counters |
| rstN | input | 1 | Asynchronous active-low reset |
| hStrobe | input | 1 | One-cycle H-rate feedback strobe |
| refFrameStart | input | 1 | One-cycle decoded reference frame start |
| cfgPixPerLine | input | PIX_W | Output pixels per line |
| cfgLinesPerFrame | input | LINE_W | Output lines per frame |
| cfgRefLines | input | LINE_W | Reference lines per frame |
| cfgLineOffset | input | LINE_W | Reference line at which alignment happens |
| cfgFrameRatio | input | RATIO_W | Numerator of reduced input/output frame-rate ratio |
| alignEn | input | 1 | Alignment enable |
| initReq | input | 1 | Alignment init request, acted on at its rising edge |
| framePulse | output | 1 | Top-of-frame pulse, high for the first output line |
| cfgInvalid | output | 1 | Line offset out of range |

## Verification
The assertions check the following on every cycle. A restart only occurs on an H strobe while the enable is set. A restart is followed by a high frame pulse. Arming requires an init edge taken with the enable set. Dropping the enable disarms the block on the next edge. The bench scenarios are needed for the cycle-accurate pulse period and width under two geometries, and for the exact strobe on which alignment lands after reference-line wraps, re-phasing and ratio gating. They are also needed to show that a held init bit or a cleared enable leaves the free-running phase untouched. A bench-side counting model predicts the pulse on every cycle around each strobe.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;
  // Strobes passed from the alignment control to the output counters.
  typedef struct packed {
    logic realign;   // restart both output counters at top of frame
  } ctl_strobe_t;
endpackage

// File: rtl/frame_ref_track.sv
module frame_ref_track #(
  parameter int LINE_W  = 11,
  parameter int RATIO_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hStrobe,
  input  logic               refFrameStart,
  input  logic [LINE_W-1:0]  cfgRefLines,
  input  logic [LINE_W-1:0]  cfgLineOffset,
  input  logic [RATIO_W-1:0] cfgFrameRatio,
  output logic               alignPoint,
  output logic               cfgInvalid
);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  logic [LINE_W-1:0]  refLine;
  logic [LINE_W-1:0]  effOffset;
  logic [RATIO_W-1:0] ratioIdx;
  logic [RATIO_W:0]   ratioNext;
  logic               lineWrap;
  logic               ratioWrap;

  always_comb begin
    cfgInvalid = (cfgLineOffset == '0) || (cfgLineOffset > cfgRefLines);
    effOffset  = cfgInvalid ? cfgRefLines : cfgLineOffset;
    lineWrap   = refLine >= cfgRefLines;
    ratioNext  = {1'b0, ratioIdx} + (RATIO_W+1)'(1);
    ratioWrap  = ratioNext >= {1'b0, cfgFrameRatio};
    alignPoint = hStrobe && !refFrameStart && (refLine == effOffset) && (ratioIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLine  <= LINE_ONE;
      ratioIdx <= '0;
    end else if (refFrameStart) begin
      refLine <= LINE_ONE;
    end else if (hStrobe) begin
      if (lineWrap) begin
        refLine  <= LINE_ONE;
        ratioIdx <= ratioWrap ? '0 : ratioNext[RATIO_W-1:0];
      end else begin
        refLine <= refLine + LINE_ONE;
      end
    end
  end
endmodule

// File: rtl/frame_align_ctl.sv
module frame_align_ctl
  import frame_align_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        alignEn,
  input  logic        initReq,
  input  logic        alignPoint,
  output ctl_strobe_t strobes,
  output logic        armed
);
  logic initPrev;
  logic initRise;

  assign initRise        = initReq && !initPrev;
  assign strobes.realign = armed && alignEn && alignPoint;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initPrev <= 1'b0;
      armed    <= 1'b0;
    end else begin
      initPrev <= initReq;
      armed    <= armed ? alignEn : (alignEn && initRise);
    end
  end
endmodule

// File: rtl/frame_out_count.sv
module frame_out_count
  import frame_align_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobes,
  input  logic [PIX_W-1:0]  cfgPixPerLine,
  input  logic [LINE_W-1:0] cfgLinesPerFrame,
  output logic              framePulse
);
  logic [PIX_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [PIX_W:0]    pixNext;
  logic [LINE_W:0]   lineNext;
  logic              pixLast;
  logic              lineLast;

  always_comb begin
    pixNext    = {1'b0, pixCnt} + (PIX_W+1)'(1);
    lineNext   = {1'b0, lineCnt} + (LINE_W+1)'(1);
    pixLast    = pixNext >= {1'b0, cfgPixPerLine};
    lineLast   = lineNext >= {1'b0, cfgLinesPerFrame};
    framePulse = lineCnt == '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (strobes.realign) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (pixLast) begin
      pixCnt  <= '0;
      lineCnt <= lineLast ? '0 : lineNext[LINE_W-1:0];
    end else begin
      pixCnt <= pixNext[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/frame_align_gen.sv
module frame_align_gen
  import frame_align_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int LINE_W  = 11,
  parameter int RATIO_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hStrobe,
  input  logic               refFrameStart,
  input  logic [PIX_W-1:0]   cfgPixPerLine,
  input  logic [LINE_W-1:0]  cfgLinesPerFrame,
  input  logic [LINE_W-1:0]  cfgRefLines,
  input  logic [LINE_W-1:0]  cfgLineOffset,
  input  logic [RATIO_W-1:0] cfgFrameRatio,
  input  logic               alignEn,
  input  logic               initReq,
  output logic               framePulse,
  output logic               cfgInvalid
);
  ctl_strobe_t strobes;
  logic        alignPoint;
  logic        armedSt;

  frame_ref_track #(.LINE_W(LINE_W), .RATIO_W(RATIO_W)) u_ref (
    .clk(clk), .rstN(rstN), .hStrobe(hStrobe), .refFrameStart(refFrameStart),
    .cfgRefLines(cfgRefLines), .cfgLineOffset(cfgLineOffset),
    .cfgFrameRatio(cfgFrameRatio), .alignPoint(alignPoint), .cfgInvalid(cfgInvalid)
  );

  frame_align_ctl u_ctl (
    .clk(clk), .rstN(rstN), .alignEn(alignEn), .initReq(initReq),
    .alignPoint(alignPoint), .strobes(strobes), .armed(armedSt)
  );

  frame_out_count #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_out (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgPixPerLine(cfgPixPerLine),
    .cfgLinesPerFrame(cfgLinesPerFrame), .framePulse(framePulse)
  );
endmodule

// File: rtl/frame_align_chk.sv
module frame_align_chk (
  input logic clk,
  input logic rstN,
  input logic hStrobe,
  input logic alignEn,
  input logic initReq,
  input logic framePulse,
  input logic realign,
  input logic armed
);
  // R1: first cycle out of reset starts a frame
  a_r1_reset_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> framePulse);

  // R6: a restart only happens on an H strobe
  a_r6_strobe_only: assert property (@(posedge clk) disable iff (!rstN)
    realign |-> hStrobe);

  // R9: no restart without the enable
  a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    realign |-> alignEn);

  // R7: a restart puts the output at top of frame
  a_r7_pulse_after_load: assert property (@(posedge clk) disable iff (!rstN)
    realign |=> framePulse);

  // R7: arming comes from an init request taken with the enable set
  a_r7_arm_on_init: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> ($past(initReq) && $past(alignEn)));

  // R9: dropping the enable disarms
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !alignEn) |=> !armed);
endmodule

bind frame_align_gen frame_align_chk u_chk (
  .clk(clk), .rstN(rstN), .hStrobe(hStrobe), .alignEn(alignEn), .initReq(initReq),
  .framePulse(framePulse), .realign(strobes.realign), .armed(armedSt)
);

// File: tb/frame_align_gen_tb.sv
`timescale 1ns/1ps
module frame_align_gen_tb;
  localparam int PIX_W   = 12;
  localparam int LINE_W  = 11;
  localparam int RATIO_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hStrobe = 1'b0;
  logic refFrameStart = 1'b0;
  logic [PIX_W-1:0]   cfgPixPerLine = PIX_W'(5);
  logic [LINE_W-1:0]  cfgLinesPerFrame = LINE_W'(4);
  logic [LINE_W-1:0]  cfgRefLines = LINE_W'(4);
  logic [LINE_W-1:0]  cfgLineOffset = LINE_W'(2);
  logic [RATIO_W-1:0] cfgFrameRatio = RATIO_W'(1);
  logic alignEn = 1'b0;
  logic initReq = 1'b0;
  logic framePulse;
  logic cfgInvalid;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int loadCyc = 0;
  bit modelValid = 1'b0;
  int refLineM = 1;
  int ratioM = 0;

  frame_align_gen #(.PIX_W(PIX_W), .LINE_W(LINE_W), .RATIO_W(RATIO_W)) u_dut (
    .clk(clk), .rstN(rstN), .hStrobe(hStrobe), .refFrameStart(refFrameStart),
    .cfgPixPerLine(cfgPixPerLine), .cfgLinesPerFrame(cfgLinesPerFrame),
    .cfgRefLines(cfgRefLines), .cfgLineOffset(cfgLineOffset),
    .cfgFrameRatio(cfgFrameRatio), .alignEn(alignEn), .initReq(initReq),
    .framePulse(framePulse), .cfgInvalid(cfgInvalid)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int expPulse();
    int pos;
    pos = (cyc - loadCyc) % (int'(cfgPixPerLine) * int'(cfgLinesPerFrame));
    return (pos < int'(cfgPixPerLine)) ? 1 : 0;
  endfunction

  function automatic int effOffM();
    if (cfgLineOffset == 0 || cfgLineOffset > cfgRefLines) return int'(cfgRefLines);
    return int'(cfgLineOffset);
  endfunction

  // one H strobe, then the pulse is compared with the model for seven cycles
  task automatic send_strobe(input bit armedExp, input string req);
    bit hit;
    hit = armedExp && (refLineM == effOffM()) && (ratioM == 0);
    @(negedge clk) hStrobe = 1'b1;
    @(negedge clk) hStrobe = 1'b0;
    if (refLineM >= int'(cfgRefLines)) begin
      refLineM = 1;
      ratioM = (ratioM + 1 >= int'(cfgFrameRatio)) ? 0 : ratioM + 1;
    end else begin
      refLineM++;
    end
    if (hit) begin
      loadCyc = cyc;
      modelValid = 1'b1;
    end
    for (int i = 0; i < 7; i++) begin
      if (i > 0) @(negedge clk);
      if (modelValid) check(framePulse == 1'(expPulse()), req, framePulse, expPulse());
    end
  endtask

  task automatic send_frame_start();
    @(negedge clk) refFrameStart = 1'b1;
    @(negedge clk) refFrameStart = 1'b0;
    refLineM = 1;
  endtask

  task automatic raise_init();
    @(negedge clk) initReq = 1'b0;
    @(negedge clk) initReq = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(framePulse == 1'b1, "R1", framePulse, 1);
    rstN = 1'b1;
    loadCyc = cyc;
    modelValid = 1'b1;
    check(framePulse == 1'b1, "R1", framePulse, 1);
    check(cfgInvalid == 1'b0, "R4", cfgInvalid, 0);
  endtask

  task automatic t_invalid();
    @(negedge clk) cfgLineOffset = '0;
    #1 check(cfgInvalid == 1'b1, "R4", cfgInvalid, 1);
    cfgLineOffset = LINE_W'(5);
    #1 check(cfgInvalid == 1'b1, "R4", cfgInvalid, 1);
    cfgLineOffset = LINE_W'(4);
    #1 check(cfgInvalid == 1'b0, "R4", cfgInvalid, 0);
    cfgLineOffset = LINE_W'(1);
    #1 check(cfgInvalid == 1'b0, "R4", cfgInvalid, 0);
    cfgLineOffset = LINE_W'(2);
  endtask

  task automatic measure(input int ppl, input int lpf);
    int r1, hi;
    @(negedge clk) cfgPixPerLine = PIX_W'(ppl);
    cfgLinesPerFrame = LINE_W'(lpf);
    modelValid = 1'b0;
    while (framePulse) @(negedge clk);
    while (!framePulse) @(negedge clk);
    r1 = cyc;
    hi = 0;
    while (framePulse) begin hi++; @(negedge clk); end
    while (!framePulse) @(negedge clk);
    check(hi == ppl, "R3", hi, ppl);
    check(cyc - r1 == ppl * lpf, "R2", cyc - r1, ppl * lpf);
  endtask

  task automatic t_freerun();
    measure(5, 4);
    measure(3, 6);
    measure(5, 4);
  endtask

  task automatic t_align();
    alignEn = 1'b1;
    send_frame_start();
    raise_init();
    send_strobe(1'b1, "R7");
    send_strobe(1'b1, "R7");
    check(modelValid == 1'b1, "R7", modelValid, 1);
    for (int k = 0; k < 4; k++) send_strobe(1'b1, "R8");
  endtask

  task automatic t_rephase();
    send_strobe(1'b1, "R5");
    send_frame_start();
    send_strobe(1'b1, "R5");
    send_strobe(1'b1, "R5");
    send_strobe(1'b1, "R5");
  endtask

  task automatic t_disarm();
    alignEn = 1'b0;
    for (int k = 0; k < 4; k++) send_strobe(1'b0, "R9");
  endtask

  task automatic t_hold();
    alignEn = 1'b1;
    for (int k = 0; k < 4; k++) send_strobe(1'b0, "R10");
  endtask

  task automatic t_ratio();
    cfgFrameRatio = RATIO_W'(2);
    cfgLineOffset = '0;
    #1 check(cfgInvalid == 1'b1, "R4", cfgInvalid, 1);
    raise_init();
    for (int k = 0; k < 12; k++) send_strobe(1'b1, "R6");
  endtask

  initial begin
    t_reset();
    t_invalid();
    t_freerun();
    t_align();
    t_rephase();
    t_disarm();
    t_hold();
    t_ratio();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #800000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule